// File: doc/BRIEF.md
# Double-Buffered Waveform Scan Sequencer

This block generates the read address that steps through a stored pulse-train waveform, one waveform step at a time. A separate step timer sends a one-cycle pulse each time the current step has run its length, and the sequencer then moves its address counter by one. A length register marks the last step of the waveform. When the step pulse arrives on that last step, the sequencer makes its end-of-waveform decision. It can exchange the two waveform memory banks and load a new waveform length in that same cycle. It then either plays the waveform again or stops.

A processor prepares the idle bank and the next length, then raises a swap request. The sequencer confirms the exchange with a one-cycle acknowledge. The processor clears the request and RUN to stop generation, and the sequencer finishes the waveform that is playing before it halts. Four run modes are available: loop, single pass, and re-triggered, where each waveform waits for an external start. The fourth mode code behaves as loop. A reverse option plays the steps from the last step down to step zero. A start enable holds off the first waveform until the external start input is high.

The address is a paced output with no back-pressure. It is held steady between step pulses, and the downstream memory must accept it every cycle. The control and status pins are plain levels or pulses.

Top module: `wave_scan_seq`

## Requirements
- R1: After reset the outputs read as follows: addr_o = 0, bank_o = 0, busy_o = 0, done_o = 0 and swap_ack_o = 0.
- R2: In the idle state, run_i high with start gating off (ext_en_i = 0) starts a waveform. On the next cycle busy_o is 1 and done_o is 0. top_next_i is loaded as the length, and addr_o is 0, or equals top_next_i when rev_i = 1.
- R3: In forward play, each step_i pulse raises addr_o by exactly 1 after one cycle, and addr_o holds when step_i is low.
- R4: A step_i pulse while addr_o equals the length register ends the waveform. In loop mode (mode_i = 0 or 3) with run_i high, addr_o is 0 on the next cycle and busy_o stays 1.
- R5: If swap_req_i is high when the waveform ends, bank_o inverts, top_next_i becomes the length, and swap_ack_o is 1 for that one cycle. swap_req_i has no effect on bank_o or swap_ack_o at any other step.
- R6: If run_i is low when the waveform ends, the next cycle shows busy_o = 0, done_o = 1 and addr_o = 0. done_o stays 1 until a new waveform starts.
- R7: Single-pass mode (mode_i = 1) stops after one waveform as in R6, and does not restart while run_i stays high. run_i must go low and then high again to start a new pass.
- R8: With rev_i = 1 the address starts at the length, falls by 1 on each step_i pulse, and the waveform ends on the step pulse taken at address 0.
- R9: With ext_en_i = 1, run_i leaves busy_o low and ignores step_i until ext_start_i is high. The waveform starts, with addr_o = 0, on the cycle after ext_start_i is sampled high.
- R10: In re-triggered mode (mode_i = 2), each waveform end with run_i high returns to waiting: busy_o = 0 and addr_o = 0. The next waveform begins on the cycle after ext_start_i is high.
- R11: With a length of 0, every step_i pulse ends a waveform, so a held swap request exchanges the banks on every step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | One-cycle pulse from the step timer |
| run_i | input | 1 | Processor request to generate |
| swap_req_i | input | 1 | Processor request to exchange banks at waveform end |
| top_next_i | input | ADDR_W | Prepared index of the last step |
| rev_i | input | 1 | Play from last step down to zero |
| mode_i | input | 2 | 0 loop, 1 single pass, 2 re-triggered, 3 loop |
| ext_en_i | input | 1 | Gate the first waveform on the external start |
| ext_start_i | input | 1 | External start level |
| addr_o | output | ADDR_W | Scan address into the playing bank |
| bank_o | output | 1 | Bank currently being played |
| busy_o | output | 1 | A waveform is playing |
| done_o | output | 1 | Generation stopped after a waveform |
| swap_ack_o | output | 1 | One-cycle confirmation of a bank exchange |

## Verification
The checker watches the following on every cycle:
- the address never passes the length while playing;
- a step in forward play adds exactly one to the address, and a step in reverse play subtracts exactly one;
- the address holds when no step arrives;
- the address is zero whenever the sequencer is not playing;
- done_o and busy_o are never high together;
- the bank changes only in a cycle that carries the acknowledge.

Only the bench scenarios show the end-of-waveform decisions themselves. These are which mode restarts or halts, whether a stop waits for RUN to be withdrawn, the length loaded on a swap, and the waiting that the external start enforces.

// File: rtl/wss_pkg.sv
package wss_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_SCAN = 2'd2,
    ST_HALT = 2'd3
  } wss_state_e;

  typedef enum logic [1:0] {
    MD_LOOP   = 2'd0,
    MD_ONCE   = 2'd1,
    MD_RETRIG = 2'd2,
    MD_SPARE  = 2'd3
  } wss_mode_e;

endpackage

// File: rtl/wss_addr_cnt.sv
module wss_addr_cnt #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  input  logic              dec_i,
  output logic [ADDR_W-1:0] cnt_o
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] cnt_q;

  // A load wins over a move; the control never asks for both moves at once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (inc_i) begin
      cnt_q <= cnt_q + ONE;
    end else if (dec_i) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/wss_bank_reg.sv
module wss_bank_reg #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              top_load_i,
  input  logic              swap_i,
  input  logic [ADDR_W-1:0] top_next_i,
  output logic [ADDR_W-1:0] top_o,
  output logic              bank_o,
  output logic              ack_o
);

  logic [ADDR_W-1:0] top_q;
  logic              bank_q;
  logic              ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q  <= '0;
      bank_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      ack_q <= swap_i;
      if (top_load_i) begin
        top_q <= top_next_i;
      end else if (swap_i) begin
        top_q  <= top_next_i;
        bank_q <= ~bank_q;
      end
    end
  end

  assign top_o  = top_q;
  assign bank_o = bank_q;
  assign ack_o  = ack_q;

endmodule

// File: rtl/wss_ctrl.sv
module wss_ctrl
  import wss_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              run_i,
  input  logic              swap_req_i,
  input  logic              rev_i,
  input  logic [1:0]        mode_i,
  input  logic              ext_en_i,
  input  logic              ext_start_i,
  input  logic [ADDR_W-1:0] cnt_i,
  input  logic [ADDR_W-1:0] top_i,
  input  logic [ADDR_W-1:0] top_next_i,
  output logic              cnt_load_o,
  output logic [ADDR_W-1:0] cnt_val_o,
  output logic              cnt_inc_o,
  output logic              cnt_dec_o,
  output logic              top_load_o,
  output logic              swap_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              dir_o
);

  wss_state_e        state_q, state_d;
  logic              dir_q, dir_d;
  logic              done_q, done_d;
  wss_mode_e         mode;
  logic              at_end;
  logic              stop_now;
  logic [ADDR_W-1:0] wave_top;

  assign mode     = wss_mode_e'(mode_i);
  assign at_end   = dir_q ? (cnt_i == '0) : (cnt_i == top_i);
  assign stop_now = !run_i || (mode == MD_ONCE);
  assign wave_top = swap_req_i ? top_next_i : top_i;

  always_comb begin
    state_d    = state_q;
    dir_d      = dir_q;
    done_d     = done_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    cnt_inc_o  = 1'b0;
    cnt_dec_o  = 1'b0;
    top_load_o = 1'b0;
    swap_o     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (run_i) begin
          top_load_o = 1'b1;
          if (ext_en_i && !ext_start_i) begin
            state_d = ST_ARM;
          end else begin
            state_d    = ST_SCAN;
            cnt_load_o = 1'b1;
            cnt_val_o  = rev_i ? top_next_i : '0;
            dir_d      = rev_i;
            done_d     = 1'b0;
          end
        end
      end
      ST_ARM: begin
        if (!run_i) begin
          state_d = ST_IDLE;
        end else if (ext_start_i) begin
          state_d    = ST_SCAN;
          cnt_load_o = 1'b1;
          cnt_val_o  = rev_i ? top_i : '0;
          dir_d      = rev_i;
          done_d     = 1'b0;
        end
      end
      ST_SCAN: begin
        if (step_i) begin
          if (!at_end) begin
            cnt_inc_o = !dir_q;
            cnt_dec_o = dir_q;
          end else begin
            swap_o     = swap_req_i;
            cnt_load_o = 1'b1;
            if (stop_now) begin
              state_d = ST_HALT;
              done_d  = 1'b1;
            end else if (mode == MD_RETRIG) begin
              state_d = ST_ARM;
            end else begin
              cnt_val_o = rev_i ? wave_top : '0;
              dir_d     = rev_i;
            end
          end
        end
      end
      ST_HALT: begin
        if (!run_i) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q == ST_SCAN);
  assign done_o = done_q;
  assign dir_o  = dir_q;

endmodule

// File: rtl/wave_scan_seq.sv
module wave_scan_seq #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              run_i,
  input  logic              swap_req_i,
  input  logic [ADDR_W-1:0] top_next_i,
  input  logic              rev_i,
  input  logic [1:0]        mode_i,
  input  logic              ext_en_i,
  input  logic              ext_start_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              bank_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              swap_ack_o
);

  logic              cnt_load;
  logic [ADDR_W-1:0] cnt_val;
  logic              cnt_inc;
  logic              cnt_dec;
  logic              top_load;
  logic              swap;
  logic [ADDR_W-1:0] cnt_w;
  logic [ADDR_W-1:0] top_w;
  logic              dir_w;

  wss_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step_i),
    .run_i      (run_i),
    .swap_req_i (swap_req_i),
    .rev_i      (rev_i),
    .mode_i     (mode_i),
    .ext_en_i   (ext_en_i),
    .ext_start_i(ext_start_i),
    .cnt_i      (cnt_w),
    .top_i      (top_w),
    .top_next_i (top_next_i),
    .cnt_load_o (cnt_load),
    .cnt_val_o  (cnt_val),
    .cnt_inc_o  (cnt_inc),
    .cnt_dec_o  (cnt_dec),
    .top_load_o (top_load),
    .swap_o     (swap),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .dir_o      (dir_w)
  );

  wss_addr_cnt #(.ADDR_W(ADDR_W)) cnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (cnt_load),
    .load_val_i(cnt_val),
    .inc_i     (cnt_inc),
    .dec_i     (cnt_dec),
    .cnt_o     (cnt_w)
  );

  wss_bank_reg #(.ADDR_W(ADDR_W)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .top_load_i(top_load),
    .swap_i    (swap),
    .top_next_i(top_next_i),
    .top_o     (top_w),
    .bank_o    (bank_o),
    .ack_o     (swap_ack_o)
  );

  assign addr_o = cnt_w;

endmodule

// File: rtl/wss_chk.sv
module wss_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              bank_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              swap_ack_o,
  input logic [ADDR_W-1:0] top_q,
  input logic              dir_q
);

  AST_ADDR_WITHIN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (addr_o <= top_q)); // R4

  AST_FWD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && step_i && !dir_q && addr_o != top_q) |=> (addr_o == ADDR_W'($past(addr_o) + 1'b1))); // R3

  AST_REV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && step_i && dir_q && addr_o != '0) |=> (addr_o == ADDR_W'($past(addr_o) - 1'b1))); // R8

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !step_i) |=> $stable(addr_o)); // R3

  AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (addr_o == '0)); // R9

  AST_DONE_EXCL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R6

  AST_BANK_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_o != $past(bank_o)) |-> swap_ack_o); // R5

endmodule

bind wave_scan_seq wss_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .step_i    (step_i),
  .addr_o    (addr_o),
  .bank_o    (bank_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .swap_ack_o(swap_ack_o),
  .top_q     (top_w),
  .dir_q     (dir_w)
);

// File: tb/wave_scan_seq_tb.sv
`timescale 1ns/1ps
module wave_scan_seq_tb_top;

  localparam int AW = 13;

  typedef struct packed {
    logic [3:0]    rq;
    logic          st, rn, sw, rv;
    logic [1:0]    md;
    logic          ee, es;
    logic [AW-1:0] tp;
    logic [AW-1:0] ea;
    logic          eb, ey, ed, ek;
  } vec_t;

  // Loop mode: length 2, then swap to length 1, then stop through RUN.
  localparam vec_t VECS [11] = '{
    '{4'd2,  1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,13'd2, 13'd0,1'b0,1'b1,1'b0,1'b0}, // R2
    '{4'd3,  1'b1,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,13'd2, 13'd1,1'b0,1'b1,1'b0,1'b0}, // R3
    '{4'd3,  1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,13'd2, 13'd1,1'b0,1'b1,1'b0,1'b0}, // R3
    '{4'd3,  1'b1,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,13'd2, 13'd2,1'b0,1'b1,1'b0,1'b0}, // R3
    '{4'd4,  1'b1,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,13'd2, 13'd0,1'b0,1'b1,1'b0,1'b0}, // R4
    '{4'd5,  1'b1,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,13'd1, 13'd1,1'b0,1'b1,1'b0,1'b0}, // R5
    '{4'd5,  1'b1,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,13'd1, 13'd2,1'b0,1'b1,1'b0,1'b0}, // R5
    '{4'd5,  1'b1,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,13'd1, 13'd0,1'b1,1'b1,1'b0,1'b1}, // R5
    '{4'd5,  1'b1,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,13'd1, 13'd1,1'b1,1'b1,1'b0,1'b0}, // R5
    '{4'd6,  1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,13'd1, 13'd0,1'b1,1'b0,1'b1,1'b0}, // R6
    '{4'd6,  1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,13'd1, 13'd0,1'b1,1'b0,1'b1,1'b0}  // R6
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          step_i = 1'b0, run_i = 1'b0, swap_req_i = 1'b0, rev_i = 1'b0;
  logic [1:0]    mode_i = 2'd0;
  logic          ext_en_i = 1'b0, ext_start_i = 1'b0;
  logic [AW-1:0] top_next_i = '0;
  logic [AW-1:0] addr_o;
  logic          bank_o, busy_o, done_o, swap_ack_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wave_scan_seq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .run_i(run_i),
    .swap_req_i(swap_req_i), .top_next_i(top_next_i), .rev_i(rev_i),
    .mode_i(mode_i), .ext_en_i(ext_en_i), .ext_start_i(ext_start_i),
    .addr_o(addr_o), .bank_o(bank_o), .busy_o(busy_o), .done_o(done_o),
    .swap_ack_o(swap_ack_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic st, input logic rn, input logic sw, input logic rv,
                       input logic [1:0] md, input logic ee, input logic es,
                       input int tp);
    @(negedge clk);
    step_i = st; run_i = rn; swap_req_i = sw; rev_i = rv;
    mode_i = md; ext_en_i = ee; ext_start_i = es; top_next_i = AW'(tp);
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    step_i = 0; run_i = 0; swap_req_i = 0; rev_i = 0;
    mode_i = 0; ext_en_i = 0; ext_start_i = 0; top_next_i = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    // R1 reset state
    chk("R1 addr", int'(addr_o), 0);
    chk("R1 bank", int'(bank_o), 0);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 ack", int'(swap_ack_o), 0);

    foreach (VECS[i]) begin
      drive(VECS[i].st, VECS[i].rn, VECS[i].sw, VECS[i].rv, VECS[i].md,
            VECS[i].ee, VECS[i].es, int'(VECS[i].tp));
      chk($sformatf("R%0d vec%0d addr", VECS[i].rq, i), int'(addr_o), int'(VECS[i].ea));
      chk($sformatf("R%0d vec%0d bank", VECS[i].rq, i), int'(bank_o), int'(VECS[i].eb));
      chk($sformatf("R%0d vec%0d busy", VECS[i].rq, i), int'(busy_o), int'(VECS[i].ey));
      chk($sformatf("R%0d vec%0d done", VECS[i].rq, i), int'(done_o), int'(VECS[i].ed));
      chk($sformatf("R%0d vec%0d ack", VECS[i].rq, i), int'(swap_ack_o), int'(VECS[i].ek));
    end

    // R8 reverse, single pass (R7)
    do_reset();
    drive(0, 1, 0, 1, 2'd1, 0, 0, 3);
    chk("R8 rev start addr", int'(addr_o), 3);
    chk("R2 rev start busy", int'(busy_o), 1);
    drive(1, 1, 0, 1, 2'd1, 0, 0, 3);
    chk("R8 rev step addr", int'(addr_o), 2);
    drive(1, 1, 0, 1, 2'd1, 0, 0, 3);
    drive(1, 1, 0, 1, 2'd1, 0, 0, 3);
    chk("R8 rev reach zero", int'(addr_o), 0);
    chk("R8 still busy at zero", int'(busy_o), 1);
    drive(1, 1, 0, 1, 2'd1, 0, 0, 3);
    chk("R7 once busy", int'(busy_o), 0);
    chk("R7 once done", int'(done_o), 1);
    drive(1, 1, 0, 1, 2'd1, 0, 0, 3);
    drive(0, 1, 0, 1, 2'd1, 0, 0, 3);
    chk("R7 no restart busy", int'(busy_o), 0);
    chk("R7 no restart addr", int'(addr_o), 0);
    drive(0, 0, 0, 0, 2'd0, 0, 0, 5);
    chk("R6 done held", int'(done_o), 1);
    drive(0, 1, 0, 0, 2'd0, 0, 0, 5);
    chk("R2 restart busy", int'(busy_o), 1);
    chk("R2 restart done clear", int'(done_o), 0);

    // R9 external start gate
    do_reset();
    drive(0, 1, 0, 0, 2'd0, 1, 0, 4);
    chk("R9 wait busy", int'(busy_o), 0);
    drive(1, 1, 0, 0, 2'd0, 1, 0, 4);
    chk("R9 step ignored busy", int'(busy_o), 0);
    chk("R9 step ignored addr", int'(addr_o), 0);
    drive(0, 1, 0, 0, 2'd0, 1, 1, 4);
    chk("R9 started busy", int'(busy_o), 1);
    chk("R9 started addr", int'(addr_o), 0);
    drive(1, 1, 0, 0, 2'd0, 1, 0, 4);
    chk("R9 first step", int'(addr_o), 1);

    // R10 re-triggered mode
    do_reset();
    drive(0, 1, 0, 0, 2'd2, 0, 0, 1);
    drive(1, 1, 0, 0, 2'd2, 0, 0, 1);
    chk("R10 step", int'(addr_o), 1);
    drive(1, 1, 0, 0, 2'd2, 0, 0, 1);
    chk("R10 waits busy", int'(busy_o), 0);
    chk("R10 waits addr", int'(addr_o), 0);
    drive(1, 1, 0, 0, 2'd2, 0, 0, 1);
    chk("R10 step ignored", int'(busy_o), 0);
    drive(0, 1, 0, 0, 2'd2, 0, 1, 1);
    chk("R10 retrigger busy", int'(busy_o), 1);
    drive(1, 1, 0, 0, 2'd2, 0, 0, 1);
    chk("R10 retrigger step", int'(addr_o), 1);

    // R11 zero length with held swap
    do_reset();
    drive(0, 1, 0, 0, 2'd3, 0, 0, 0);
    chk("R11 start busy", int'(busy_o), 1);
    drive(1, 1, 1, 0, 2'd3, 0, 0, 0);
    chk("R11 bank first", int'(bank_o), 1);
    chk("R11 ack first", int'(swap_ack_o), 1);
    chk("R11 addr", int'(addr_o), 0);
    drive(1, 1, 1, 0, 2'd3, 0, 0, 0);
    chk("R11 bank second", int'(bank_o), 0);
    drive(1, 1, 0, 0, 2'd3, 0, 0, 0);
    chk("R11 ack cleared", int'(swap_ack_o), 0);
    chk("R11 still busy", int'(busy_o), 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule